// File: doc/BRIEF.md
# I2C Combined-Transfer Chunk Sequencer

This block sits between a transfer-level controller and an I2C byte engine whose command can move at most four bytes. A transfer is a run of messages that all go to one target. Each message carries a length, a direction and a flag that marks it as the final message. On a start pulse the sequencer first checks that the bus is idle. It then takes messages one at a time from a ready/valid stream and turns each one into chunk commands of one to four bytes. Each command carries a direction and two position flags. The chain flag tells the engine to keep the bus between chunks. The repeated-start flag tells it to turn the bus around into the next message.

For a write chunk, the sequencer first pulses a buffer-load strobe with the byte count and then issues the command. For a read chunk, it pulses an unload strobe after a good completion. Every completion is checked against the chunk size. A short count or an engine error ends the transfer. The sequencer then asks the engine to abandon the bus if that bus would otherwise be left held.

A lone zero-length message is passed to a separate quick-command path rather than to the byte engine. Each transfer ends with a one-cycle done pulse. The pulse carries a pass/fail bit and the number of messages that were fully completed.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of length L is sent as ceil(L/4) commands, and each command moves min(remaining, 4) bytes. `cmd_cnt` carries the byte count minus one (00 = 1 byte, 11 = 4 bytes).
- R2: `cmd_chain` is 1 on every command of a message except its last one.
- R3: On the last command of a message, `cmd_chain` is 0. `cmd_rstart` is 1 there if the message is not marked final, and 0 if it is. `cmd_rstart` is 0 on every other command.
- R4: `cmd_rd` equals the read flag of the message that the command belongs to (1 = read).
- R5: Each write command is preceded, in the cycle just before it, by a one-cycle `buf_load` with `buf_cnt` equal to the chunk's byte count. Each read chunk that completes correctly is followed by one `buf_unload` with `buf_cnt` equal to its byte count. A failed read chunk produces no unload.
- R6: If the first message has zero length and is marked final, the block pulses `quick_req` together with `done`, reports `done_ok`=1 and `done_msgs`=1, and issues no command. A zero-length message in any other position fails the transfer, and no command is issued for it.
- R7: A message whose address or address-width flag differs from those of the first message fails the transfer before any command is issued for it. `done_msgs` then reports the number of messages completed before it.
- R8: A completion with `cmp_err`=1, or with `cmp_count` different from the chunk size, ends the transfer with `done_ok`=0 and `done_msgs` set to the number of fully completed messages. `abort` pulses together with `done` if and only if that message had chunks left or was not marked final.
- R9: If `bus_free` is 0 when `start` is seen, the block pulses `recover_req` together with `done`, reports `done_ok`=0 and `done_msgs`=0, takes no message and issues no command.
- R10: A transfer in which every chunk completes correctly ends with a single-cycle `done`, `done_ok`=1, and `done_msgs` equal to the number of messages.
- R11: `cmd_valid` is a one-cycle pulse, and no second command is issued before the completion of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken while idle) |
| bus_free | input | 1 | Bus idle indication, sampled when starting |
| msg_valid | input | 1 | Message descriptor present |
| msg_ready | output | 1 | Sequencer takes a descriptor this cycle |
| msg_len | input | LEN_W | Message length in bytes |
| msg_rd | input | 1 | 1 = read, 0 = write |
| msg_last | input | 1 | Final message of the transfer |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | Address is 10-bit |
| cmd_valid | output | 1 | Chunk command pulse |
| cmd_cnt | output | 2 | Chunk byte count minus one |
| cmd_rd | output | 1 | Chunk direction |
| cmd_chain | output | 1 | Keep the bus after this chunk |
| cmd_rstart | output | 1 | Repeated start after this chunk |
| cmp_valid | input | 1 | Engine completion pulse |
| cmp_count | input | 3 | Bytes actually moved |
| cmp_err | input | 1 | Engine reported an error |
| buf_load | output | 1 | Load write bytes into the data buffer |
| buf_unload | output | 1 | Unload read bytes from the data buffer |
| buf_cnt | output | 3 | Byte count for the load or unload |
| abort | output | 1 | Ask the engine to release the bus |
| recover_req | output | 1 | Bus found busy at start |
| quick_req | output | 1 | Hand a lone zero-length message to the quick path |
| done | output | 1 | Transfer finished |
| done_ok | output | 1 | Transfer passed |
| done_msgs | output | MSG_W | Messages fully completed |

## Verification
The bench uses lengths of 4, 5, 8 and 9 to hit the chunk boundary. A wrong ceiling or remainder there drops a trailing 1-byte chunk or sends a 5-byte one. It runs combined transfers that mix reads and writes, because a design that keys the repeated-start flag to the chunk rather than to the message would set it between chunks or on the final message. It injects failures in three places: mid-message, on the last chunk of a non-final message, and on the last chunk of the final message. The first two must raise `abort` and the third must not. A design that aborts on every failure, or on none, is caught. Zero-length, address-mismatch and busy-bus starts check that no command leaks out and that `done_msgs` counts only the messages that finished.

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq #(
  parameter int LEN_W = 8,
  parameter int MSG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             bus_free,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             msg_rd,
  input  logic             msg_last,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  output logic             cmd_valid,
  output logic [1:0]       cmd_cnt,
  output logic             cmd_rd,
  output logic             cmd_chain,
  output logic             cmd_rstart,
  input  logic             cmp_valid,
  input  logic [2:0]       cmp_count,
  input  logic             cmp_err,
  output logic             buf_load,
  output logic             buf_unload,
  output logic [2:0]       buf_cnt,
  output logic             abort,
  output logic             recover_req,
  output logic             quick_req,
  output logic             done,
  output logic             done_ok,
  output logic [MSG_W-1:0] done_msgs
);

  typedef enum logic [2:0] {S_IDLE, S_MSG, S_LOAD, S_ISSUE, S_WAIT, S_UNLOAD} st_t;

  st_t              st;
  logic [LEN_W-1:0] rem;
  logic             rd_q, last_q, first_q, ten_q;
  logic [9:0]       addr_q;
  logic [MSG_W-1:0] cnt_q;

  logic       big, good, adv;
  logic [2:0] csize, cm1;

  assign big   = rem > LEN_W'(4);
  assign csize = big ? 3'd4 : rem[2:0];
  assign cm1   = csize - 3'd1;
  assign good  = !cmp_err && (cmp_count == csize);
  assign adv   = (st == S_WAIT && cmp_valid && good && !rd_q) || st == S_UNLOAD;

  assign msg_ready  = st == S_MSG;
  assign cmd_valid  = st == S_ISSUE;
  assign buf_load   = st == S_LOAD;
  assign buf_unload = st == S_UNLOAD;
  assign buf_cnt    = csize;
  assign cmd_cnt    = cm1[1:0];
  assign cmd_rd     = rd_q;
  assign cmd_chain  = big;
  assign cmd_rstart = !big && !last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rem <= '0;
      rd_q <= 1'b0;
      last_q <= 1'b0;
      first_q <= 1'b0;
      ten_q <= 1'b0;
      addr_q <= '0;
      cnt_q <= '0;
      done <= 1'b0;
      done_ok <= 1'b0;
      done_msgs <= '0;
      abort <= 1'b0;
      recover_req <= 1'b0;
      quick_req <= 1'b0;
    end else begin
      done <= 1'b0;
      abort <= 1'b0;
      recover_req <= 1'b0;
      quick_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cnt_q <= '0;
          first_q <= 1'b1;
          if (!bus_free) begin
            recover_req <= 1'b1;
            done <= 1'b1;
            done_ok <= 1'b0;
            done_msgs <= '0;
          end else st <= S_MSG;
        end
        S_MSG: if (msg_valid) begin
          first_q <= 1'b0;
          if (msg_len == '0) begin
            done <= 1'b1;
            st <= S_IDLE;
            if (first_q && msg_last) begin
              quick_req <= 1'b1;
              done_ok <= 1'b1;
              done_msgs <= MSG_W'(1);
            end else begin
              done_ok <= 1'b0;
              done_msgs <= cnt_q;
            end
          end else if (!first_q && (msg_addr != addr_q || msg_ten != ten_q)) begin
            done <= 1'b1;
            done_ok <= 1'b0;
            done_msgs <= cnt_q;
            st <= S_IDLE;
          end else begin
            rem <= msg_len;
            rd_q <= msg_rd;
            last_q <= msg_last;
            if (first_q) begin
              addr_q <= msg_addr;
              ten_q <= msg_ten;
            end
            st <= msg_rd ? S_ISSUE : S_LOAD;
          end
        end
        S_LOAD:  st <= S_ISSUE;
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (cmp_valid && !good) begin
            done <= 1'b1;
            done_ok <= 1'b0;
            done_msgs <= cnt_q;
            abort <= big || !last_q;
            st <= S_IDLE;
          end else if (cmp_valid && rd_q) st <= S_UNLOAD;
        end
        default: ;
      endcase
      if (adv) begin
        rem <= rem - LEN_W'(csize);
        if (!big) begin
          cnt_q <= cnt_q + MSG_W'(1);
          if (last_q) begin
            done <= 1'b1;
            done_ok <= 1'b1;
            done_msgs <= cnt_q + MSG_W'(1);
            st <= S_IDLE;
          end else st <= S_MSG;
        end else st <= rd_q ? S_ISSUE : S_LOAD;
      end
    end
  end

  p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_load_then_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> cmd_valid && !cmd_rd);
  p_unload_after_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unload |-> $past(cmp_valid));
  p_chain_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_chain |-> cmd_cnt == 2'd3 && !cmd_rstart);
  p_abort_fails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> done && !done_ok);
  p_recover_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    recover_req |-> done && !done_ok && done_msgs == '0);
  p_quick_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quick_req |-> done && done_ok);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_i2c_chunk_seq.sv
module tb_i2c_chunk_seq;
  localparam int LEN_W = 8;
  localparam int MSG_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, bus_free = 1'b1;
  logic msg_valid = 1'b0, msg_rd = 1'b0, msg_last = 1'b0, msg_ten = 1'b0;
  logic [LEN_W-1:0] msg_len = '0;
  logic [9:0] msg_addr = '0;
  logic cmp_valid = 1'b0, cmp_err = 1'b0;
  logic [2:0] cmp_count = '0;
  logic msg_ready, cmd_valid, cmd_rd, cmd_chain, cmd_rstart;
  logic [1:0] cmd_cnt;
  logic buf_load, buf_unload, abort, recover_req, quick_req, done, done_ok;
  logic [2:0] buf_cnt;
  logic [MSG_W-1:0] done_msgs;

  always #2 clk = ~clk;

  i2c_chunk_seq #(.LEN_W(LEN_W), .MSG_W(MSG_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_free(bus_free),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_len(msg_len),
    .msg_rd(msg_rd), .msg_last(msg_last), .msg_addr(msg_addr), .msg_ten(msg_ten),
    .cmd_valid(cmd_valid), .cmd_cnt(cmd_cnt), .cmd_rd(cmd_rd),
    .cmd_chain(cmd_chain), .cmd_rstart(cmd_rstart),
    .cmp_valid(cmp_valid), .cmp_count(cmp_count), .cmp_err(cmp_err),
    .buf_load(buf_load), .buf_unload(buf_unload), .buf_cnt(buf_cnt),
    .abort(abort), .recover_req(recover_req), .quick_req(quick_req),
    .done(done), .done_ok(done_ok), .done_msgs(done_msgs));

  int vectors = 0, miscompares = 0;
  int m_len[8];
  bit m_rd[8], m_ten[8];
  logic [9:0] m_addr[8];
  int n_msg, fault_chunk, fault_kind;
  int exp_cmd[$];
  int exp_unl[$];
  bit exp_ok, exp_abort, exp_quick, exp_recover;
  int exp_msgs;
  bit req = 0, active = 0, pend = 0;
  int idx = 0, wcnt = 0, eng_chunk = 0, eng_size = 0;
  bit eng_rd = 0;
  string tag;

  task automatic chk(input bit ok, input string req_s, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s [%s] actual=%0d expected=%0d @%0t", req_s, tag, act, expv, $time);
    end
  endtask

  task automatic build_model();
    int g, rem, c;
    exp_cmd.delete(); exp_unl.delete();
    exp_abort = 0; exp_quick = 0; exp_recover = 0;
    if (!bus_free) begin
      exp_recover = 1; exp_ok = 0; exp_msgs = 0; return;
    end
    g = 0;
    for (int i = 0; i < n_msg; i++) begin
      if (m_len[i] == 0) begin
        if (n_msg == 1) begin exp_quick = 1; exp_ok = 1; exp_msgs = 1; end
        else begin exp_ok = 0; exp_msgs = i; end
        return;
      end
      if (i > 0 && (m_addr[i] != m_addr[0] || m_ten[i] != m_ten[0])) begin
        exp_ok = 0; exp_msgs = i; return;
      end
      rem = m_len[i];
      while (rem > 0) begin
        c = rem < 4 ? rem : 4;
        exp_cmd.push_back((c - 1) * 8 + int'(m_rd[i]) * 4 + (rem > 4 ? 2 : 0)
                          + ((rem <= 4 && i != n_msg - 1) ? 1 : 0));
        if (g == fault_chunk) begin
          exp_ok = 0; exp_msgs = i; exp_abort = (rem > 4) || (i != n_msg - 1);
          return;
        end
        if (m_rd[i]) exp_unl.push_back(c);
        g++; rem -= c;
      end
    end
    exp_ok = 1; exp_msgs = n_msg;
  endtask

  always @(negedge clk) begin
    cmp_valid = 1'b0;
    cmp_err = 1'b0;
    if (req && !active) begin
      start = 1'b1; active = 1; idx = 0; pend = 0; eng_chunk = 0; wcnt = 0;
    end else start = 1'b0;
    if (active) begin
      if (cmd_valid) begin
        int got, e;
        got = int'(cmd_cnt) * 8 + int'(cmd_rd) * 4 + int'(cmd_chain) * 2 + int'(cmd_rstart);
        e = exp_cmd.size() > 0 ? exp_cmd.pop_front() : -1;
        chk(got == e, "R1/R2/R3/R4 cmd fields", got, e);
        eng_size = int'(cmd_cnt) + 1; eng_rd = cmd_rd; wcnt = 2;
      end else if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) begin
          cmp_valid = 1'b1;
          cmp_count = 3'(eng_size);
          if (eng_chunk == fault_chunk) begin
            if (fault_kind == 0) cmp_count = 3'(eng_size - 1);
            else cmp_err = 1'b1;
          end
          eng_chunk++;
        end
      end
      if (buf_load) begin
        int e;
        e = exp_cmd.size() > 0 ? (exp_cmd[0] / 8 + 1) : -1;
        chk(int'(buf_cnt) == e && (exp_cmd[0] & 4) == 0, "R5 load", int'(buf_cnt), e);
      end
      if (buf_unload) begin
        int e;
        e = exp_unl.size() > 0 ? exp_unl.pop_front() : -1;
        chk(int'(buf_cnt) == e, "R5 unload", int'(buf_cnt), e);
      end
      if (done) begin
        chk(done_ok == exp_ok, "R10 done_ok", int'(done_ok), int'(exp_ok));
        chk(int'(done_msgs) == exp_msgs, "R7/R8 done_msgs", int'(done_msgs), exp_msgs);
        chk(abort == exp_abort, "R8 abort", int'(abort), int'(exp_abort));
        chk(quick_req == exp_quick, "R6 quick_req", int'(quick_req), int'(exp_quick));
        chk(recover_req == exp_recover, "R9 recover_req", int'(recover_req), int'(exp_recover));
        chk(exp_cmd.size() == 0, "R1 missing commands", exp_cmd.size(), 0);
        chk(exp_unl.size() == 0, "R5 missing unloads", exp_unl.size(), 0);
        active = 0;
      end
    end else begin
      if (cmd_valid || done || abort || quick_req || recover_req || buf_load || buf_unload)
        chk(0, "R11 stray output while idle", 1, 0);
    end
    if (pend) begin idx++; pend = 0; end
    if (active && idx < n_msg) begin
      msg_valid = 1'b1; msg_len = LEN_W'(m_len[idx]); msg_rd = m_rd[idx];
      msg_last = (idx == n_msg - 1); msg_addr = m_addr[idx]; msg_ten = m_ten[idx];
      if (msg_ready) pend = 1;
    end else msg_valid = 1'b0;
  end

  task automatic run(input string t, input int n, input int fc, input int fk, input bit bf);
    int w;
    tag = t; n_msg = n; fault_chunk = fc; fault_kind = fk; bus_free = bf;
    build_model();
    @(posedge clk); req = 1;
    wait (active);
    @(posedge clk); req = 0;
    w = 0;
    while (active && w < 500) begin @(posedge clk); w++; end
    if (active) begin chk(0, "R10 watchdog", w, 0); active = 0; end
    repeat (3) @(posedge clk);
  endtask

  task automatic setm(input int i, input int len, input bit rd, input int a, input bit ten);
    m_len[i] = len; m_rd[i] = rd; m_addr[i] = 10'(a); m_ten[i] = ten;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(done == 0 && cmd_valid == 0 && msg_ready == 0 && abort == 0, "R10 reset state",
        int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    setm(0, 1, 0, 'h50, 0);
    run("R1 single write 1", 1, -1, 0, 1);
    setm(0, 9, 0, 'h50, 0);
    run("R1 R2 write 9", 1, -1, 0, 1);
    setm(0, 4, 1, 'h21, 0);
    run("R1 read 4", 1, -1, 0, 1);
    setm(0, 5, 0, 'h21, 0); setm(1, 4, 1, 'h21, 0); setm(2, 8, 1, 'h21, 0);
    run("R3 R4 R5 combined", 3, -1, 0, 1);
    setm(0, 0, 0, 'h33, 0);
    run("R6 quick", 1, -1, 0, 1);
    setm(0, 3, 0, 'h33, 0); setm(1, 0, 1, 'h33, 0);
    run("R6 zero second", 2, -1, 0, 1);
    setm(0, 0, 0, 'h33, 0); setm(1, 2, 1, 'h33, 0);
    run("R6 zero first of two", 2, -1, 0, 1);
    setm(0, 2, 0, 'h40, 0); setm(1, 2, 1, 'h41, 0);
    run("R7 addr mismatch", 2, -1, 0, 1);
    setm(0, 2, 0, 'h40, 0); setm(1, 3, 0, 'h40, 0); setm(2, 1, 1, 'h40, 1);
    run("R7 width mismatch", 3, -1, 0, 1);
    setm(0, 9, 1, 'h12, 0);
    run("R8 short mid msg", 1, 0, 0, 1);
    setm(0, 2, 1, 'h12, 0);
    run("R8 short last final", 1, 0, 0, 1);
    setm(0, 6, 1, 'h12, 0); setm(1, 4, 0, 'h12, 0);
    run("R8 err last of nonfinal", 2, 1, 1, 1);
    setm(0, 3, 0, 'h12, 0); setm(1, 6, 1, 'h12, 0);
    run("R8 err final last", 2, 2, 1, 1);
    setm(0, 3, 0, 'h12, 0);
    run("R9 bus busy", 1, -1, 0, 0);
    setm(0, 3, 0, 'h12, 0);
    run("R9 recovered", 1, -1, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #400000;
    miscompares++;
    $display("FAIL R10 global watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule